// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register interface that sits in front of a three-channel interval timer. A host issues one access per cycle to one of four addresses: three data ports, one per counter channel, and a control port. Control writes program a channel's byte-access pattern, counting mode and BCD flag. They can also freeze a channel's count for a later read, or run a read-back command that freezes counts and status bytes of several channels at once. Data writes are assembled into 16-bit initial counts and handed to the counter channels with a one-cycle load strobe.

The counting itself lives outside. Each channel feeds back its live count and OUT level. The front end returns bytes of those values, or of frozen copies, following each channel's byte pointer. The host side is a request stream with a valid qualifier and no ready. Every access presented with `acc_valid` high is taken in that cycle, so there is no back-pressure. A read produces exactly one response beat, with `rsp_valid` high, in the following cycle. The response stream cannot be stalled.

Top module: `tmr_regif`

## Requirements
- R1: After reset every channel uses low-byte-only access, mode 0 and binary counting. No frozen count or status is pending, `ld_stb` is zero and `rsp_valid` is low.
- R2: A write to address 3 whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are nonzero programs that channel. Bits 5:4 set the access pattern (1 = low byte only, 2 = high byte only, 3 = low then high). Bits 3:1 set the mode, and bit 0 sets BCD. Mode codes 6 and 7 are stored as 2 and 3, so `ch_mode` never exceeds 5.
- R3: In low-only access a data write loads `{8'h00, byte}`. In high-only access it loads `{byte, 8'h00}`. The load shows as a one-cycle pulse on that channel's `ld_stb` bit in the cycle after the write. Control writes never pulse `ld_stb`.
- R4: In low-then-high access the first data byte is held without a load. The second byte loads `{second, first}`.
- R5: Unfrozen reads return the live count's low byte in low-only access and its high byte in high-only access. In low-then-high access they alternate low, high, low, starting with low.
- R6: Programming a channel returns both its write and its read byte pointers to the low byte.
- R7: A control word with bits 5:4 = 0 freezes the addressed channel's live count as seen in that cycle, and leaves its mode and access unchanged. Reads then return the frozen bytes in the channel's access order. The freeze is released after the single byte in one-byte access, or after the high byte in two-byte access. Reads after release return the live count.
- R8: A count freeze request for a channel whose frozen count is not fully read is ignored.
- R9: A control word with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2, any number at once. Bit 5 = 0 freezes each selected channel's count. Unselected channels are unaffected.
- R10: Bit 4 = 0 in a read-back command freezes a status byte: bit 7 = OUT, bit 6 = 0, bits 5:4 = access, bits 3:1 = mode, bit 0 = BCD. A pending status is returned by the next read, ahead of any frozen count, and is then cleared.
- R11: A status freeze request for a channel whose status has not been read is ignored.
- R12: A read of address 3 returns zero.
- R13: Every read produces `rsp_valid` high with its data in exactly the next cycle. Back-to-back reads give back-to-back responses, and `rsp_valid` is low in any cycle not following a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request valid, always accepted |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | 0..2 channel data ports, 3 control port |
| acc_wdata | input | BYTE_W | Write byte |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_data | output | BYTE_W | Read response byte |
| cnt_live | input | NUM_CH*2*BYTE_W | Live counts from the channels, channel 0 in the low slice |
| out_lvl | input | NUM_CH | OUT level of each channel |
| ld_stb | output | NUM_CH | One-cycle count load pulse per channel |
| ld_val | output | NUM_CH*2*BYTE_W | Count to load, per channel slice |
| ch_mode | output | NUM_CH*3 | Programmed mode per channel |
| ch_bcd | output | NUM_CH | Programmed BCD flag per channel |

## Verification
The bench builds the block with its defaults: three channels and byte width 8, giving 16-bit counts. With these values the read-back channel-select bits 1 to 3 each map to a real channel, so a single command can freeze two channels at once while a third stays live. Every status byte field sits at its documented position and can be compared bit for bit. The bench acts as the counter channels: it drives distinct live counts and OUT levels, and changes them after each freeze to show that the frozen bytes come from the command cycle.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd3;

  // access pattern; the freeze tracker reuses the same codes, NONE meaning idle
  typedef enum logic [1:0] {
    AM_NONE = 2'd0,
    AM_LO   = 2'd1,
    AM_HI   = 2'd2,
    AM_WORD = 2'd3
  } acc_mode_e;

  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] raw);
    return (raw > 3'd5) ? raw - 3'd4 : raw;
  endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input  logic                  acc_valid,
  input  logic                  acc_we,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [BYTE_W-1:0]     acc_wdata,
  output logic [NUM_CH-1:0]     prog,
  output logic [NUM_CH-1:0]     cnt_frz,
  output logic [NUM_CH-1:0]     sts_frz,
  output logic [NUM_CH-1:0]     wr_stb,
  output logic [NUM_CH-1:0]     rd_stb,
  output acc_mode_e             prog_am,
  output logic [MODE_W-1:0]     prog_mode,
  output logic                  prog_bcd
);
  logic       ctrl_wr;
  logic [1:0] sel;
  logic       is_rb;

  assign ctrl_wr   = acc_valid && acc_we && (acc_addr == CTRL_ADDR);
  assign sel       = acc_wdata[7:6];
  assign is_rb     = (sel == 2'd3);
  assign prog_am   = acc_mode_e'(acc_wdata[5:4]);
  assign prog_mode = fold_mode(acc_wdata[3:1]);
  assign prog_bcd  = acc_wdata[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit, rb_sel;
    assign hit        = ctrl_wr && !is_rb && (sel == 2'(c));
    assign rb_sel     = ctrl_wr && is_rb && acc_wdata[c+1];
    assign prog[c]    = hit && (prog_am != AM_NONE);
    assign cnt_frz[c] = (hit && (prog_am == AM_NONE)) || (rb_sel && !acc_wdata[5]);
    assign sts_frz[c] = rb_sel && !acc_wdata[4];
    assign wr_stb[c]  = acc_valid && acc_we && (acc_addr == ADDR_W'(c));
    assign rd_stb[c]  = acc_valid && !acc_we && (acc_addr == ADDR_W'(c));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_regif_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  acc_mode_e         prog_am,
  input  logic [MODE_W-1:0] prog_mode,
  input  logic              prog_bcd,
  input  logic              cnt_frz,
  input  logic              sts_frz,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_stb,
  input  logic [CNT_W-1:0]  live,
  input  logic              out_lvl,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              ld_stb,
  output logic [CNT_W-1:0]  ld_val,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o
);
  acc_mode_e         am_q, frz_q;
  logic [MODE_W-1:0] mode_q;
  logic              bcd_q;
  logic              wr_hi_q, rd_hi_q;
  logic [BYTE_W-1:0] wr_hold_q;
  logic [CNT_W-1:0]  frz_cnt_q;
  logic              sts_pend_q;
  logic [BYTE_W-1:0] sts_q;
  logic [BYTE_W-1:0] sts_now;

  assign sts_now = BYTE_W'({out_lvl, 1'b0, am_q, mode_q, bcd_q});
  assign mode_o  = mode_q;
  assign bcd_o   = bcd_q;

  always_comb begin
    if (sts_pend_q)
      rd_byte = sts_q;
    else if (frz_q != AM_NONE)
      rd_byte = (frz_q == AM_HI) ? frz_cnt_q[CNT_W-1:BYTE_W] : frz_cnt_q[BYTE_W-1:0];
    else if ((am_q == AM_HI) || ((am_q == AM_WORD) && rd_hi_q))
      rd_byte = live[CNT_W-1:BYTE_W];
    else
      rd_byte = live[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      am_q       <= AM_LO;
      frz_q      <= AM_NONE;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      wr_hold_q  <= '0;
      frz_cnt_q  <= '0;
      sts_pend_q <= 1'b0;
      sts_q      <= '0;
      ld_stb     <= 1'b0;
      ld_val     <= '0;
    end else begin
      ld_stb <= 1'b0;
      if (prog) begin
        am_q    <= prog_am;
        mode_q  <= prog_mode;
        bcd_q   <= prog_bcd;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (cnt_frz && (frz_q == AM_NONE)) begin
        frz_q     <= am_q;
        frz_cnt_q <= live;
      end
      if (sts_frz && !sts_pend_q) begin
        sts_pend_q <= 1'b1;
        sts_q      <= sts_now;
      end
      if (wr_stb) begin
        unique case (am_q)
          AM_HI: begin
            ld_stb <= 1'b1;
            ld_val <= {wr_byte, {BYTE_W{1'b0}}};
          end
          AM_WORD: begin
            if (!wr_hi_q) begin
              wr_hold_q <= wr_byte;
              wr_hi_q   <= 1'b1;
            end else begin
              ld_stb  <= 1'b1;
              ld_val  <= {wr_byte, wr_hold_q};
              wr_hi_q <= 1'b0;
            end
          end
          default: begin
            ld_stb <= 1'b1;
            ld_val <= {{BYTE_W{1'b0}}, wr_byte};
          end
        endcase
      end
      if (rd_stb) begin
        if (sts_pend_q)
          sts_pend_q <= 1'b0;
        else if (frz_q != AM_NONE)
          frz_q <= (frz_q == AM_WORD) ? AM_HI : AM_NONE;
        else if (am_q == AM_WORD)
          rd_hi_q <= !rd_hi_q;
      end
    end
  end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid,
  input  logic                     acc_we,
  input  logic [1:0]               acc_addr,
  input  logic [BYTE_W-1:0]        acc_wdata,
  output logic                     rsp_valid,
  output logic [BYTE_W-1:0]        rsp_data,
  input  logic [NUM_CH*CNT_W-1:0]  cnt_live,
  input  logic [NUM_CH-1:0]        out_lvl,
  output logic [NUM_CH-1:0]        ld_stb,
  output logic [NUM_CH*CNT_W-1:0]  ld_val,
  output logic [NUM_CH*MODE_W-1:0] ch_mode,
  output logic [NUM_CH-1:0]        ch_bcd
);
  logic [NUM_CH-1:0] prog, cnt_frz, sts_frz, wr_stb, rd_stb;
  acc_mode_e         prog_am;
  logic [MODE_W-1:0] prog_mode;
  logic              prog_bcd;
  logic [BYTE_W-1:0] rd_byte [NUM_CH];
  logic [BYTE_W-1:0] rd_sel;

  tmr_cmd_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
    .acc_valid (acc_valid),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .prog      (prog),
    .cnt_frz   (cnt_frz),
    .sts_frz   (sts_frz),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .prog_am   (prog_am),
    .prog_mode (prog_mode),
    .prog_bcd  (prog_bcd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_chan_regs #(.BYTE_W(BYTE_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog      (prog[c]),
      .prog_am   (prog_am),
      .prog_mode (prog_mode),
      .prog_bcd  (prog_bcd),
      .cnt_frz   (cnt_frz[c]),
      .sts_frz   (sts_frz[c]),
      .wr_stb    (wr_stb[c]),
      .wr_byte   (acc_wdata),
      .rd_stb    (rd_stb[c]),
      .live      (cnt_live[c*CNT_W +: CNT_W]),
      .out_lvl   (out_lvl[c]),
      .rd_byte   (rd_byte[c]),
      .ld_stb    (ld_stb[c]),
      .ld_val    (ld_val[c*CNT_W +: CNT_W]),
      .mode_o    (ch_mode[c*MODE_W +: MODE_W]),
      .bcd_o     (ch_bcd[c])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (acc_addr == 2'(c)) rd_sel = rd_byte[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_valid && !acc_we;
      if (acc_valid && !acc_we)
        rsp_data <= (acc_addr == CTRL_ADDR) ? '0 : rd_sel;
    end
  end
endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     acc_valid,
  input logic                     acc_we,
  input logic [1:0]               acc_addr,
  input logic                     rsp_valid,
  input logic [BYTE_W-1:0]        rsp_data,
  input logic [NUM_CH-1:0]        ld_stb,
  input logic [NUM_CH*MODE_W-1:0] ch_mode
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_we) |=> rsp_valid); // R13
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_we) |=> !rsp_valid); // R13
  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_we && acc_addr == CTRL_ADDR) |=> (rsp_data == '0)); // R12
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb)); // R3
  AST_LOAD_FROM_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb != '0) |-> $past(acc_valid && acc_we && acc_addr != CTRL_ADDR)); // R3
  AST_CTRL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && acc_addr == CTRL_ADDR) |=> (ld_stb == '0)); // R3
  for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      ch_mode[c*MODE_W +: MODE_W] <= 3'd5); // R2
  end
endmodule

bind tmr_regif tmr_regif_chk #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_we    (acc_we),
  .acc_addr  (acc_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .ld_stb    (ld_stb),
  .ch_mode   (ch_mode)
);

// File: tb/tb_tmr_regif.sv
`timescale 1ns/1ps
module tb_tmr_regif;
  localparam int NCH = 3;
  localparam int BW  = 8;
  localparam int CW  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           acc_valid = 1'b0, acc_we = 1'b0;
  logic [1:0]     acc_addr = '0;
  logic [BW-1:0]  acc_wdata = '0;
  logic           rsp_valid;
  logic [BW-1:0]  rsp_data;
  logic [NCH*CW-1:0] cnt_live = '0;
  logic [NCH-1:0] out_lvl = '0;
  logic [NCH-1:0] ld_stb;
  logic [NCH*CW-1:0] ld_val;
  logic [NCH*3-1:0] ch_mode;
  logic [NCH-1:0] ch_bcd;

  int n_chk = 0, n_bad = 0;
  logic [NCH-1:0] got_stb;
  logic [NCH*CW-1:0] got_val;
  logic [BW-1:0]  rb;
  logic           rv;

  always #4 clk = ~clk;

  tmr_regif dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .cnt_live(cnt_live), .out_lvl(out_lvl),
    .ld_stb(ld_stb), .ld_val(ld_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0;
    got_stb = ld_stb; got_val = ld_val;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    rv = rsp_valid; rb = rsp_data;
  endtask

  task automatic set_live(input int c, input logic [15:0] v);
    cnt_live[c*CW +: CW] = v;
  endtask

  task automatic t_reset;
    chk("R1 ld_stb", 32'(ld_stb), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 ch_mode", 32'(ch_mode), 0);
    chk("R1 ch_bcd", 32'(ch_bcd), 0);
    set_live(0, 16'h1234);
    rd(2'd0); chk("R1 low-only read", 32'(rb), 32'h34);
    rd(2'd0); chk("R1 low-only read again", 32'(rb), 32'h34);
  endtask

  task automatic t_single;
    wr(2'd3, 8'h55);
    chk("R2 mode ch1", 32'(ch_mode[5:3]), 2);
    chk("R2 bcd ch1", 32'(ch_bcd[1]), 1);
    chk("R3 ctrl write no load", 32'(got_stb), 0);
    wr(2'd1, 8'h7C);
    chk("R3 low-only strobe", 32'(got_stb), 32'b010);
    chk("R3 low-only value", 32'(got_val[31:16]), 32'h007C);
    wr(2'd3, 8'h66);
    wr(2'd1, 8'h9D);
    chk("R3 high-only strobe", 32'(got_stb), 32'b010);
    chk("R3 high-only value", 32'(got_val[31:16]), 32'h9D00);
  endtask

  task automatic t_mode_fold;
    wr(2'd3, 8'hBC);
    chk("R2 mode 6 folds to 2", 32'(ch_mode[8:6]), 2);
    wr(2'd3, 8'hBE);
    chk("R2 mode 7 folds to 3", 32'(ch_mode[8:6]), 3);
  endtask

  task automatic t_word;
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h11);
    chk("R4 first byte no load", 32'(got_stb), 0);
    wr(2'd0, 8'h22);
    chk("R4 second byte strobe", 32'(got_stb), 32'b001);
    chk("R4 assembled value", 32'(got_val[15:0]), 32'h2211);
  endtask

  task automatic t_live;
    wr(2'd3, 8'h30);
    wr(2'd3, 8'h66);
    set_live(0, 16'hBEEF);
    set_live(1, 16'h4321);
    rd(2'd0); chk("R5 word read low", 32'(rb), 32'hEF);
    rd(2'd0); chk("R5 word read high", 32'(rb), 32'hBE);
    rd(2'd0); chk("R5 word read low again", 32'(rb), 32'hEF);
    rd(2'd1); chk("R5 high-only read", 32'(rb), 32'h43);
    rd(2'd1); chk("R5 high-only read again", 32'(rb), 32'h43);
  endtask

  task automatic t_ptr_reset;
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h55);
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h01);
    chk("R6 write pointer reset, no load", 32'(got_stb), 0);
    wr(2'd0, 8'h02);
    chk("R6 write pointer reset value", 32'(got_val[15:0]), 32'h0201);
    set_live(0, 16'hBEEF);
    rd(2'd0);
    wr(2'd3, 8'h30);
    rd(2'd0); chk("R6 read pointer reset", 32'(rb), 32'hEF);
  endtask

  task automatic t_latch;
    wr(2'd3, 8'h38);
    set_live(0, 16'h1357);
    wr(2'd3, 8'h00);
    chk("R7 mode kept after freeze", 32'(ch_mode[2:0]), 4);
    set_live(0, 16'h9999);
    wr(2'd3, 8'h00);
    rd(2'd0); chk("R8 second freeze ignored low", 32'(rb), 32'h57);
    rd(2'd0); chk("R7 frozen high", 32'(rb), 32'h13);
    rd(2'd0); chk("R7 live after release", 32'(rb), 32'h99);
    rd(2'd0);
    set_live(0, 16'h2468);
    wr(2'd3, 8'h00);
    set_live(0, 16'h0000);
    rd(2'd0); chk("R8 refreeze after release low", 32'(rb), 32'h68);
    rd(2'd0); chk("R8 refreeze after release high", 32'(rb), 32'h24);
    wr(2'd3, 8'h52);
    set_live(1, 16'hCAFE);
    wr(2'd3, 8'h40);
    set_live(1, 16'h0102);
    rd(2'd1); chk("R7 low-only frozen byte", 32'(rb), 32'hFE);
    rd(2'd1); chk("R7 low-only released", 32'(rb), 32'h02);
  endtask

  task automatic t_readback;
    wr(2'd3, 8'h38);
    wr(2'd3, 8'h52);
    wr(2'd3, 8'h97);
    set_live(0, 16'hA0B0);
    set_live(1, 16'h5566);
    set_live(2, 16'h00C3);
    wr(2'd3, 8'hDA);
    set_live(0, 16'h0F0F);
    set_live(2, 16'h0F0F);
    rd(2'd0); chk("R9 ch0 frozen low", 32'(rb), 32'hB0);
    rd(2'd0); chk("R9 ch0 frozen high", 32'(rb), 32'hA0);
    rd(2'd2); chk("R9 ch2 frozen", 32'(rb), 32'hC3);
    rd(2'd1); chk("R9 unselected ch1 live", 32'(rb), 32'h66);
    rd(2'd2); chk("R9 ch2 released", 32'(rb), 32'h0F);
  endtask

  task automatic t_status;
    wr(2'd3, 8'h38);
    wr(2'd3, 8'h97);
    out_lvl = 3'b100;
    set_live(2, 16'h00D4);
    wr(2'd3, 8'hC8);
    set_live(2, 16'h0077);
    rd(2'd2); chk("R10 status first", 32'(rb), 32'h97);
    rd(2'd2); chk("R10 count after status", 32'(rb), 32'hD4);
    rd(2'd2); chk("R10 live after both", 32'(rb), 32'h77);
    set_live(0, 16'h3344);
    wr(2'd3, 8'hE2);
    out_lvl = 3'b101;
    wr(2'd3, 8'hE2);
    rd(2'd0); chk("R11 second status ignored", 32'(rb), 32'h38);
    rd(2'd0); chk("R10 status cleared after read", 32'(rb), 32'h44);
  endtask

  task automatic t_ctrl_read;
    rd(2'd3);
    chk("R12 control read zero", 32'(rb), 0);
    chk("R13 response valid", 32'(rv), 1);
    wr(2'd3, 8'h52);
    wr(2'd3, 8'h97);
    set_live(1, 16'h00A1);
    set_live(2, 16'h00B2);
    @(negedge clk);
    acc_valid = 1'b1; acc_we = 1'b0; acc_addr = 2'd1;
    @(negedge clk);
    acc_addr = 2'd2;
    chk("R13 first beat valid", 32'(rsp_valid), 1);
    chk("R13 first beat data", 32'(rsp_data), 32'hA1);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R13 second beat valid", 32'(rsp_valid), 1);
    chk("R13 second beat data", 32'(rsp_data), 32'hB2);
    @(negedge clk);
    chk("R13 idle after reads", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_mode_fold();
    t_word();
    t_live();
    t_ptr_reset();
    t_latch();
    t_readback();
    t_status();
    t_ctrl_read();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule